// File: doc/BRIEF.md
# Memory Word Increment/Decrement Sequencer

This block performs an in-place increment or decrement of a value that lives in memory. A request names the operation, the 16-bit address, a code that selects one of three address spaces (normal, X or Y), and the current flag byte. The sequencer then drives a byte-wide synchronous memory port through the reads and writes the operation needs. It computes the new value and the new flag byte, and signals completion with a one-cycle `done` pulse. A byte operation touches one location. A word operation touches two consecutive locations, low byte first. Two conditional byte operations do their work only when the incoming X flag is set. Otherwise they finish at once without any memory cycle.

The controller is one enumerated state machine with these states: `ST_IDLE`, `ST_RD_LO`, `ST_RD_HI`, `ST_CAPTURE`, `ST_WR_LO`, `ST_WR_HI` and `ST_FINISH`. It has these transitions:
- `ST_IDLE` goes to `ST_RD_LO` on an accepted request.
- `ST_IDLE` goes to `ST_FINISH` on a skipped or unused request.
- `ST_RD_LO` goes to `ST_RD_HI` for a word, or to `ST_CAPTURE` for a byte.
- `ST_RD_HI` goes to `ST_CAPTURE`.
- `ST_CAPTURE` goes to `ST_WR_LO`.
- `ST_WR_LO` goes to `ST_WR_HI` for a word, or to `ST_FINISH` for a byte.
- `ST_WR_HI` goes to `ST_FINISH`.
- `ST_FINISH` goes to `ST_IDLE`.

The memory returns read data on the cycle after a read strobe. `start` is only looked at in `ST_IDLE`.

Top module: `mstep_seq`

## Requirements
- R1: With `sel_idx` = 0 the space comes from the low three bits of `sel_code`: 4 gives X (`mem_space` = 1), 5 gives Y (`mem_space` = 2), anything else gives normal (`mem_space` = 0). The space stays fixed for every access of one request.
- R2: With `sel_idx` = 1 the space comes from the low two bits of `sel_code`: 0 gives X (1), 1 gives Y (2), anything else gives normal (0). `mem_space` never takes the value 3.
- R3: A byte operation (`op` 0 = increment, 1 = decrement, or a conditional one that runs) does exactly one read and then one write, both at `addr`. Read and write strobes are never high together.
- R4: Byte increment flags, using flag bits S=7, Z=6, H=4, X=3, V=2, N=1, C=0: S is result bit 7; Z means the result is zero; H means the result's low nibble is zero; X means the operand was 0xFF; V means the operand was 0x7F; N is cleared. C and bit 5 keep their incoming values.
- R5: Byte decrement flags: S is result bit 7; Z means the result is zero; H means the operand's low nibble was zero; X means the operand was 0x00; V means the operand was 0x80; N is set. C and bit 5 keep their incoming values.
- R6: A word operation (`op` 4 = increment, 5 = decrement) reads `addr` as the low byte and then addr+1 as the high byte. It then writes the low byte to `addr` and the high byte to addr+1. addr+1 wraps modulo 2^16.
- R7: Word increment flags: X and V are set exactly when the operand was 0xFFFF. S is result bit 15, Z means the result is zero, and N is cleared. H, C and bit 5 keep their incoming values.
- R8: Word decrement flags: X and V are set exactly when the operand was 0x0000. S is result bit 15, Z means the result is zero, and N is cleared. H, C and bit 5 keep their incoming values.
- R9: The conditional byte increment (`op` 2) and conditional byte decrement (`op` 3) behave like `op` 0 and 1 when the incoming X flag (bit 3) is set. When X is clear they make no memory access and return the incoming flags unchanged.
- R10: `done` is high for exactly one cycle. Counting the cycle after the `start` edge as latency 1, `done` arrives at latency 1 for a skipped request, 4 for a byte operation and 6 for a word operation. After reset, `done`, `mem_rd` and `mem_wr` are low.
- R11: `op` codes 6 and 7 do nothing. They make no memory access, return the incoming flags unchanged, and finish at latency 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken in idle |
| op | input | 3 | Operation code (0..5 valid) |
| sel_idx | input | 1 | 0: register-style code, 1: index-style code |
| sel_code | input | 3 | Space select code |
| addr | input | 16 | Target address |
| flags_in | input | 8 | Flag byte at request time |
| flags_out | output | 8 | Updated flag byte, valid with `done` |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory address |
| mem_space | output | 2 | Address space: 0 normal, 1 X, 2 Y |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |

## Verification
The bench goes after the wrap points. These are byte operands 0xFF, 0x7F, 0x00 and 0x80, nibble borrow and carry values, and word operands 0xFFFF and 0x0000 placed at address 0xFFFF.
- A wrong flag rule shows up as a miscomputed X, V or H bit.
- A missing address wrap puts the high byte somewhere other than 0x0000.
- A swapped access order writes the halves to the wrong locations.

Conditional operations are driven with X both set and clear. A design that ignored the condition would show stray memory cycles, a changed flag byte or the wrong `done` latency. Every register and index code is exercised, so a mis-decoded space shows up as accesses in the wrong space.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

    // Flag byte bit positions
    localparam int FB_S = 7;
    localparam int FB_Z = 6;
    localparam int FB_H = 4;
    localparam int FB_X = 3;
    localparam int FB_V = 2;
    localparam int FB_N = 1;
    localparam int FLAG_W = 8;

    typedef enum logic [1:0] {
        SPACE_NORM = 2'd0,
        SPACE_X    = 2'd1,
        SPACE_Y    = 2'd2
    } space_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_CAPTURE,
        ST_WR_LO,
        ST_WR_HI,
        ST_FINISH
    } state_e;

    // Operation code fields
    typedef struct packed {
        logic valid;
        logic is_word;
        logic is_cond;
        logic is_dec;
    } opdec_t;

    function automatic opdec_t decode_op(input logic [2:0] code);
        opdec_t d;
        d.valid   = (code <= 3'd5);
        d.is_word = (code == 3'd4) || (code == 3'd5);
        d.is_cond = (code == 3'd2) || (code == 3'd3);
        d.is_dec  = code[0];
        return d;
    endfunction

endpackage

// File: rtl/mstep_space_dec.sv
module mstep_space_dec
    import mstep_pkg::*;
(
    input  logic       idx_mode,
    input  logic [2:0] code,
    output logic [1:0] space
);
    space_e sp;

    always_comb begin
        sp = SPACE_NORM;
        if (idx_mode) begin
            unique case (code[1:0])
                2'd0:    sp = SPACE_X;
                2'd1:    sp = SPACE_Y;
                default: sp = SPACE_NORM;
            endcase
        end else begin
            unique case (code)
                3'd4:    sp = SPACE_X;
                3'd5:    sp = SPACE_Y;
                default: sp = SPACE_NORM;
            endcase
        end
    end

    assign space = sp;
endmodule

// File: rtl/mstep_alu.sv
module mstep_alu
    import mstep_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  is_dec,
    input  logic                  is_word,
    input  logic [2*DATA_W-1:0]   opnd,
    input  logic [FLAG_W-1:0]     flags_in,
    output logic [2*DATA_W-1:0]   result,
    output logic [FLAG_W-1:0]     flags_out
);
    localparam int WW = 2 * DATA_W;
    localparam logic [DATA_W-1:0] B_POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] B_NEG_MIN = ~B_POS_MAX;
    localparam logic [DATA_W-1:0] B_ONES    = '1;
    localparam logic [WW-1:0]     W_ONES    = '1;

    logic [DATA_W-1:0] b_in;
    logic [DATA_W-1:0] b_res;
    logic [WW-1:0]     w_res;

    always_comb begin
        b_in  = opnd[DATA_W-1:0];
        b_res = is_dec ? (b_in - 1'b1) : (b_in + 1'b1);
        w_res = is_dec ? (opnd - 1'b1) : (opnd + 1'b1);

        flags_out = flags_in;
        if (is_word) begin
            result           = w_res;
            flags_out[FB_S]  = w_res[WW-1];
            flags_out[FB_Z]  = (w_res == '0);
            flags_out[FB_X]  = is_dec ? (opnd == '0) : (opnd == W_ONES);
            flags_out[FB_V]  = flags_out[FB_X];
            flags_out[FB_N]  = 1'b0;
        end else begin
            result           = {{DATA_W{1'b0}}, b_res};
            flags_out[FB_S]  = b_res[DATA_W-1];
            flags_out[FB_Z]  = (b_res == '0);
            flags_out[FB_H]  = is_dec ? (b_in[3:0] == 4'h0) : (b_res[3:0] == 4'h0);
            flags_out[FB_X]  = is_dec ? (b_in == '0) : (b_in == B_ONES);
            flags_out[FB_V]  = is_dec ? (b_in == B_NEG_MIN) : (b_in == B_POS_MAX);
            flags_out[FB_N]  = is_dec;
        end
    end
endmodule

// File: rtl/mstep_seq.sv
module mstep_seq
    import mstep_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic              sel_idx,
    input  logic [2:0]        sel_code,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        flags_in,
    output logic [7:0]        flags_out,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_space,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int WW = 2 * DATA_W;

    state_e            state_q, state_d;
    opdec_t            req_dec;
    logic [1:0]        space_sel;
    logic [1:0]        space_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_hi;
    logic              word_q, dec_q;
    logic [DATA_W-1:0] lo_q;
    logic [WW-1:0]     result_q;
    logic [FLAG_W-1:0] flags_q;
    logic [WW-1:0]     alu_opnd;
    logic [WW-1:0]     alu_res;
    logic [FLAG_W-1:0] alu_flags;
    logic              accept, skip;

    assign req_dec = decode_op(op);
    assign accept  = (state_q == ST_IDLE) && start;
    assign skip    = !req_dec.valid || (req_dec.is_cond && !flags_in[FB_X]);
    assign addr_hi = addr_q + 1'b1;

    mstep_space_dec u_space (
        .idx_mode (sel_idx),
        .code     (sel_code),
        .space    (space_sel)
    );

    assign alu_opnd = word_q ? {mem_rdata, lo_q} : {{DATA_W{1'b0}}, mem_rdata};

    mstep_alu #(.DATA_W(DATA_W)) u_alu (
        .is_dec    (dec_q),
        .is_word   (word_q),
        .opnd      (alu_opnd),
        .flags_in  (flags_q),
        .result    (alu_res),
        .flags_out (alu_flags)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = skip ? ST_FINISH : ST_RD_LO;
            ST_RD_LO:   state_d = word_q ? ST_RD_HI : ST_CAPTURE;
            ST_RD_HI:   state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_WR_LO;
            ST_WR_LO:   state_d = word_q ? ST_WR_HI : ST_FINISH;
            ST_WR_HI:   state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Request and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            space_q  <= SPACE_NORM;
            word_q   <= 1'b0;
            dec_q    <= 1'b0;
            lo_q     <= '0;
            result_q <= '0;
            flags_q  <= '0;
        end else begin
            if (accept) begin
                addr_q  <= addr;
                space_q <= space_sel;
                word_q  <= req_dec.is_word;
                dec_q   <= req_dec.is_dec;
                flags_q <= flags_in;
            end
            if (state_q == ST_RD_HI) lo_q <= mem_rdata;
            if (state_q == ST_CAPTURE) begin
                result_q <= alu_res;
                flags_q  <= alu_flags;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = result_q[DATA_W-1:0];
        done      = 1'b0;
        unique case (state_q)
            ST_RD_LO:  mem_rd = 1'b1;
            ST_RD_HI:  begin mem_rd = 1'b1; mem_addr = addr_hi; end
            ST_WR_LO:  mem_wr = 1'b1;
            ST_WR_HI:  begin
                mem_wr    = 1'b1;
                mem_addr  = addr_hi;
                mem_wdata = result_q[WW-1:DATA_W];
            end
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    assign mem_space = space_q;
    assign flags_out = flags_q;
endmodule

// File: rtl/mstep_chk.sv
module mstep_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_space
);
    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_HI_READ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R6

    AST_HI_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R6

    AST_SPACE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && $past(mem_rd || mem_wr)) |-> $stable(mem_space)); // R1

    AST_SPACE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_space != 2'd3); // R2
endmodule

bind mstep_seq mstep_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_space (mem_space)
);

// File: tb/mstep_seq_tb_top.sv
module mstep_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic        sel_idx = 1'b0;
    logic [2:0]  sel_code = '0;
    logic [15:0] addr = '0;
    logic [7:0]  flags_in = '0;
    logic [7:0]  flags_out;
    logic        done;
    logic [15:0] mem_addr;
    logic [1:0]  mem_space;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mstep_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .sel_idx(sel_idx),
        .sel_code(sel_code), .addr(addr), .flags_in(flags_in), .flags_out(flags_out),
        .done(done), .mem_addr(mem_addr), .mem_space(mem_space), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: three spaces, indexed by the low address byte
    logic [7:0]  mem [0:2][0:255];
    logic        clr = 1'b0;
    int          nr = 0, nw = 0;
    logic [15:0] ra [0:1];
    logic [15:0] wa [0:1];
    logic [1:0]  exp_sp = '0;
    logic        sp_bad = 1'b0;

    always @(posedge clk) begin
        if (clr) begin
            nr <= 0; nw <= 0; sp_bad <= 1'b0;
        end else begin
            if (mem_rd) begin
                mem_rdata <= mem[(mem_space > 2'd2) ? 2'd0 : mem_space][mem_addr[7:0]];
                if (nr < 2) ra[nr] <= mem_addr;
                nr <= nr + 1;
                if (mem_space !== exp_sp) sp_bad <= 1'b1;
            end
            if (mem_wr) begin
                mem[(mem_space > 2'd2) ? 2'd0 : mem_space][mem_addr[7:0]] <= mem_wdata;
                if (nw < 2) wa[nw] <= mem_addr;
                nw <= nw + 1;
                if (mem_space !== exp_sp) sp_bad <= 1'b1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] space_of(input logic idx, input logic [2:0] c);
        if (idx) return (c[1:0] == 2'd0) ? 2'd1 : (c[1:0] == 2'd1) ? 2'd2 : 2'd0;
        return (c == 3'd4) ? 2'd1 : (c == 3'd5) ? 2'd2 : 2'd0;
    endfunction

    // Returns {flags, result16}
    function automatic logic [23:0] model(input logic dec, input logic word,
                                          input logic [15:0] v, input logic [7:0] f);
        logic [7:0]  nf = f;
        logic [7:0]  r8;
        logic [15:0] r16;
        if (word) begin
            r16   = dec ? v - 16'd1 : v + 16'd1;
            nf[7] = r16[15];
            nf[6] = (r16 == 16'h0);
            nf[3] = dec ? (v == 16'h0000) : (v == 16'hFFFF);
            nf[2] = nf[3];
            nf[1] = 1'b0;
            return {nf, r16};
        end
        r8    = dec ? v[7:0] - 8'd1 : v[7:0] + 8'd1;
        nf[7] = r8[7];
        nf[6] = (r8 == 8'h0);
        nf[4] = dec ? (v[3:0] == 4'h0) : (r8[3:0] == 4'h0);
        nf[3] = dec ? (v[7:0] == 8'h00) : (v[7:0] == 8'hFF);
        nf[2] = dec ? (v[7:0] == 8'h80) : (v[7:0] == 8'h7F);
        nf[1] = dec;
        return {nf, 8'h00, r8};
    endfunction

    task automatic run_op(input logic [2:0] o, input logic idx, input logic [2:0] c,
                          input logic [15:0] a, input logic [7:0] f, input logic [7:0] lo_v,
                          input logic [7:0] hi_v);
        logic [1:0]  sp = space_of(idx, c);
        logic [15:0] a1 = a + 16'd1;
        logic        valid = (o <= 3'd5);
        logic        word = (o == 3'd4) || (o == 3'd5);
        logic        cond = (o == 3'd2) || (o == 3'd3);
        logic        active = valid && !(cond && !f[3]);
        logic [23:0] e;
        int          lat;
        int          exp_lat;
        string       rq;
        mem[sp][a[7:0]] = lo_v;
        if (word) mem[sp][a1[7:0]] = hi_v;
        e = model(o[0], word, {hi_v, lo_v}, f);
        rq = !valid ? "R11" : (cond ? "R9" : (word ? (o[0] ? "R8" : "R7") : (o[0] ? "R5" : "R4")));
        exp_lat = !active ? 1 : (word ? 6 : 4);
        exp_sp = sp;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        op = o; sel_idx = idx; sel_code = c; addr = a; flags_in = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check({rq, " flags"}, flags_out, active ? e[23:16] : f);
        check("R10 done latency", lat, exp_lat);
        check(word ? "R6 access count" : "R3 access count", nr + nw * 16,
              active ? (word ? 2 + 32 : 1 + 16) : 0);
        check(idx ? "R2 space" : "R1 space", sp_bad, 1'b0);
        if (active) begin
            check(word ? "R6 read lo addr" : "R3 read addr", ra[0], a);
            check(word ? "R6 write lo addr" : "R3 write addr", wa[0], a);
            check({rq, " lo result"}, mem[sp][a[7:0]], e[7:0]);
            if (word) begin
                check("R6 read hi addr", ra[1], a1);
                check("R6 write hi addr", wa[1], a1);
                check({rq, " hi result"}, mem[sp][a1[7:0]], e[15:8]);
            end
        end else begin
            check({rq, " memory untouched"}, mem[sp][a[7:0]], lo_v);
        end
        @(negedge clk);
        check("R10 done single", done, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int s = 0; s < 3; s++)
            for (int i = 0; i < 256; i++) mem[s][i] = 8'h00;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset done", done, 1'b0);
        check("R10 reset rd", mem_rd, 1'b0);
        check("R10 reset wr", mem_wr, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Byte corners: R4, R5
        run_op(3'd0, 0, 3'd0, 16'h0010, 8'h21, 8'hFF, 8'h00);
        run_op(3'd0, 0, 3'd0, 16'h0011, 8'h00, 8'h7F, 8'h00);
        run_op(3'd0, 0, 3'd0, 16'h0012, 8'hFF, 8'h0F, 8'h00);
        run_op(3'd1, 0, 3'd0, 16'h0013, 8'h00, 8'h00, 8'h00);
        run_op(3'd1, 0, 3'd0, 16'h0014, 8'hFF, 8'h80, 8'h00);
        run_op(3'd1, 0, 3'd0, 16'h0015, 8'h20, 8'h10, 8'h00);
        // Word corners with address wrap: R6, R7, R8
        run_op(3'd4, 0, 3'd4, 16'hFFFF, 8'h00, 8'hFF, 8'hFF);
        run_op(3'd5, 0, 3'd5, 16'hFFFF, 8'hFF, 8'h00, 8'h00);
        run_op(3'd4, 1, 3'd0, 16'h1234, 8'h10, 8'hFF, 8'h7F);
        run_op(3'd5, 1, 3'd1, 16'h1234, 8'h00, 8'h00, 8'h80);
        // Conditional: R9
        run_op(3'd2, 0, 3'd0, 16'h0040, 8'h00, 8'h55, 8'h00);
        run_op(3'd3, 0, 3'd0, 16'h0041, 8'hF7, 8'h55, 8'h00);
        run_op(3'd2, 0, 3'd0, 16'h0042, 8'h08, 8'hFF, 8'h00);
        run_op(3'd3, 1, 3'd2, 16'h0043, 8'h08, 8'h00, 8'h00);
        // Unused codes: R11
        run_op(3'd6, 0, 3'd0, 16'h0050, 8'hA5, 8'h33, 8'h00);
        run_op(3'd7, 1, 3'd0, 16'h0051, 8'h5A, 8'h33, 8'h00);
        // Every select code: R1, R2
        for (int c = 0; c < 8; c++) begin
            run_op(3'd0, 0, 3'(c), 16'h0060, 8'h00, 8'(c), 8'h00);
            run_op(3'd1, 1, 3'(c), 16'h0061, 8'h00, 8'(c), 8'h00);
        end
        // Random mix
        for (int k = 0; k < 300; k++) begin
            run_op(3'($urandom_range(0, 7)), 1'($urandom), 3'($urandom),
                   16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule